// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block decides, cycle by cycle, when the high-side and low-side switches of a synchronous buck half-bridge may be enabled. It takes the PWM request and two comparator flags: one says the switch node has dropped below its threshold, the other says the low-side gate has discharged. It never closes one switch until the sensed condition shows the other has really opened. The dead time therefore follows the power stage, not a fixed delay.

Inductor current can flow backwards. The switch node then stays high after the high-side opens, and the switch-node flag never arrives. A watchdog counts the wait and turns the low side on anyway, so the reverse current has a path. A free-running period counter cuts the high-side request at 80 % of each switching period. Two inputs from a protection block override the PWM request. Force-off opens both switches. Force-low-side opens the high side and holds the low side closed, still through the normal break-before-make path.

Top module: `gate_sequencer`

## Requirements
- R1: While reset is asserted, `hsEn` and `lsEn` are both 0.
- R2: `hsEn` and `lsEn` are never 1 in the same cycle.
- R3: After the high side opens, `lsEn` goes to 1 on the clock edge that samples `swNodeLow` = 1, provided the watchdog has not already acted. `lsEn` never rises in the cycle right after `hsEn` was 1.
- R4: `hsEn` rises only on the edge after `lsGateLow` = 1 is sampled, and only after a waiting cycle in which both enables are 0.
- R5: If `swNodeLow` stays 0 after `hsEn` falls, `lsEn` rises exactly `WD_CYCLES` clock cycles after the fall (default 8).
- R6: With the request held high, `hsEn` stays high for at most `PERIOD_CLKS*MAX_DUTY_PCT/100` consecutive cycles (80 % of the period). It returns each period.
- R7: While `forceLs` = 1 and `forceOff` = 0, `hsEn` is 0 from the next edge. The low side turns on through the R3 path, or at once if the high side was not on. It then stays on regardless of `pwmCmd`.
- R8: `forceOff` = 1 drives both enables to 0 from the next edge and takes priority over `forceLs`.
- R9: While the low side is on, `pwmCmd` = 0 keeps it on. If `pwmCmd` drops while waiting for `lsGateLow`, the low side turns back on instead of the high side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwmCmd | input | 1 | High-side request from the modulator |
| swNodeLow | input | 1 | Comparator: switch node below threshold |
| lsGateLow | input | 1 | Comparator: low-side gate below threshold |
| forceOff | input | 1 | Protection: open both switches |
| forceLs | input | 1 | Protection: open high side, hold low side on |
| hsEn | output | 1 | High-side gate enable |
| lsEn | output | 1 | Low-side gate enable |

## Verification
Two actions can fall in the same cycle:
- **Protection override with a turn-on in progress.** `forceLs` is raised in the cycle that would have closed the high side after `lsGateLow`, and again while the high side is already on. The check is that the low side wins without any overlap.
- **`forceOff` and `forceLs` together.** Both are raised at once, and both enables must go low.

The watchdog expiry and the 80 % cut are each exercised in their own run starting from reset. In those runs the exact edge of `lsEn` and the longest `hsEn` run are compared against counts derived from the parameters.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HS_ON,
    ST_WAIT_SW,
    ST_LS_ON,
    ST_WAIT_LG
  } gseq_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic wdRun;
  } gseq_strobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic dutyOk;
    logic wdExpired;
  } gseq_flags_t;

endpackage

// File: rtl/gseq_datapath.sv
module gseq_datapath #(
  parameter int PERIOD_CLKS  = 20,
  parameter int MAX_DUTY_PCT = 80,
  parameter int WD_CYCLES    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  gseq_pkg::gseq_strobe_t strobe,
  output gseq_pkg::gseq_flags_t  flags
);
  localparam int DUTY_LIM = (PERIOD_CLKS * MAX_DUTY_PCT) / 100;
  localparam int PW       = $clog2(PERIOD_CLKS + 1);
  localparam int WW       = $clog2(WD_CYCLES + 1);

  logic [PW-1:0] periodCnt;
  logic [WW-1:0] wdCnt;
  logic          wdHit;

  // switching period counter, free running from reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      periodCnt <= '0;
    else if (periodCnt == PW'(PERIOD_CLKS - 1))
      periodCnt <= '0;
    else
      periodCnt <= periodCnt + 1'b1;
  end

  assign wdHit = (wdCnt == WW'(WD_CYCLES - 1));

  // wait timer for the switch-node-low flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wdCnt <= '0;
    else if (!strobe.wdRun)
      wdCnt <= '0;
    else if (!wdHit)
      wdCnt <= wdCnt + 1'b1;
  end

  assign flags.dutyOk    = (periodCnt < PW'(DUTY_LIM));
  assign flags.wdExpired = strobe.wdRun && wdHit;

endmodule

// File: rtl/gseq_control.sv
module gseq_control (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwmCmd,
  input  logic                   swNodeLow,
  input  logic                   lsGateLow,
  input  logic                   forceOff,
  input  logic                   forceLs,
  input  gseq_pkg::gseq_flags_t  flags,
  output gseq_pkg::gseq_strobe_t strobe,
  output logic                   hsEn,
  output logic                   lsEn
);
  import gseq_pkg::*;

  gseq_state_e state, stateNxt;
  logic        hsReq;

  assign hsReq = pwmCmd && flags.dutyOk && !forceLs;

  always_comb begin
    stateNxt = state;
    if (forceOff) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:    stateNxt = hsReq ? ST_WAIT_LG : ST_WAIT_SW;
        ST_HS_ON:   if (!hsReq) stateNxt = ST_WAIT_SW;
        ST_WAIT_SW: if (swNodeLow || flags.wdExpired) stateNxt = ST_LS_ON;
        ST_LS_ON:   if (hsReq) stateNxt = ST_WAIT_LG;
        ST_WAIT_LG: begin
          if (!hsReq)         stateNxt = ST_LS_ON;
          else if (lsGateLow) stateNxt = ST_HS_ON;
        end
        default:    stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  assign strobe.wdRun = (state == ST_WAIT_SW);
  assign hsEn         = (state == ST_HS_ON);
  assign lsEn         = (state == ST_LS_ON);

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
  parameter int PERIOD_CLKS  = 20,
  parameter int MAX_DUTY_PCT = 80,
  parameter int WD_CYCLES    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwmCmd,
  input  logic swNodeLow,
  input  logic lsGateLow,
  input  logic forceOff,
  input  logic forceLs,
  output logic hsEn,
  output logic lsEn
);
  gseq_pkg::gseq_strobe_t strobe;
  gseq_pkg::gseq_flags_t  flags;

  gseq_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwmCmd(pwmCmd), .swNodeLow(swNodeLow),
    .lsGateLow(lsGateLow), .forceOff(forceOff), .forceLs(forceLs),
    .flags(flags), .strobe(strobe), .hsEn(hsEn), .lsEn(lsEn)
  );

  gseq_datapath #(
    .PERIOD_CLKS(PERIOD_CLKS), .MAX_DUTY_PCT(MAX_DUTY_PCT), .WD_CYCLES(WD_CYCLES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .flags(flags)
  );

endmodule

// File: rtl/gate_sequencer_chk.sv
module gate_sequencer_chk #(
  parameter int WD_CYCLES = 8,
  parameter int DUTY_LIM  = 16
) (
  input logic clk,
  input logic rst_n,
  input logic lsGateLow,
  input logic forceOff,
  input logic forceLs,
  input logic hsEn,
  input logic lsEn
);
  logic        lastWasHs;
  logic [15:0] gapCnt;
  logic [15:0] hsRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastWasHs <= 1'b0;
      gapCnt    <= '0;
      hsRun     <= '0;
    end else begin
      if (hsEn)                   lastWasHs <= 1'b1;
      else if (lsEn || forceOff)  lastWasHs <= 1'b0;
      if (!lastWasHs || hsEn || lsEn || forceOff) gapCnt <= '0;
      else                                        gapCnt <= gapCnt + 1'b1;
      hsRun <= hsEn ? hsRun + 1'b1 : '0;
    end
  end

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hsEn && lsEn));

  // R3
  ls_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsEn) |-> !$past(hsEn));

  // R4
  hs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsEn) |-> ($past(lsGateLow) && !$past(lsEn)));

  // R5
  wd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gapCnt <= 16'(WD_CYCLES));

  // R6
  duty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsRun <= 16'(DUTY_LIM));

  // R7
  force_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (forceLs && !forceOff) |=> !hsEn);

  // R8
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forceOff |=> (!hsEn && !lsEn));

endmodule

bind gate_sequencer gate_sequencer_chk #(
  .WD_CYCLES(WD_CYCLES),
  .DUTY_LIM((PERIOD_CLKS * MAX_DUTY_PCT) / 100)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lsGateLow(lsGateLow), .forceOff(forceOff),
  .forceLs(forceLs), .hsEn(hsEn), .lsEn(lsEn)
);

// File: tb/gate_sequencer_bench.sv
module gate_sequencer_bench;
  localparam int PERIOD = 100;
  localparam int DUTY   = (PERIOD * 80) / 100;
  localparam int WD     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwmCmd = 1'b0, swNodeLow = 1'b0, lsGateLow = 1'b0;
  logic forceOff = 1'b0, forceLs = 1'b0;
  logic hsEn, lsEn;
  int   nChecks = 0;
  int   nFails  = 0;

  always #5 clk = ~clk;

  gate_sequencer #(.PERIOD_CLKS(PERIOD), .MAX_DUTY_PCT(80), .WD_CYCLES(WD)) u_gate_sequencer (
    .clk(clk), .rst_n(rst_n), .pwmCmd(pwmCmd), .swNodeLow(swNodeLow),
    .lsGateLow(lsGateLow), .forceOff(forceOff), .forceLs(forceLs),
    .hsEn(hsEn), .lsEn(lsEn)
  );

  typedef struct packed {
    logic pwm, sw, lg, fOff, fLs, expHs, expLs;
    logic [3:0] req;
  } vec_t;

  // each row: inputs applied, then one edge, then outputs compared
  localparam vec_t VECS [25] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd3}, // R3 idle -> wait for node
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1, 4'd3}, // R3 node low -> LS on
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd4}, // R4 LS off, wait gate
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd4}, // R4 gate still high
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0, 4'd4}, // R4 gate low -> HS on
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0, 4'd2}, // R2 HS holds
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd3}, // R3 HS off, node high
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd3}, // R3 still waiting
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1, 4'd3}, // R3 node falls -> LS
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd9}, // R9 begin HS turn-on
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1, 4'd9}, // R9 request dropped -> LS back
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd4}, // R4 wait state
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1, 4'd7}, // R7 force LS beats turn-on
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1, 4'd7}, // R7 LS held despite pwm
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd4}, // R4 release, wait
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0, 4'd4}, // R4 HS on
    '{1'b1,1'b0,1'b1,1'b0,1'b1, 1'b0,1'b0, 4'd7}, // R7 force LS opens HS
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1, 4'd7}, // R7 LS on after node low
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0, 4'd8}, // R8 force off
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0, 4'd8}, // R8 off beats force LS
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd4}, // R4 restart, gate high
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b0, 4'd4}, // R4 HS on
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0, 4'd8}, // R8 force off from HS
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd9}, // R9 idle, pwm low
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1, 4'd9}  // R9 LS on with pwm low
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic applyReset();
    rst_n = 1'b0;
    pwmCmd = 1'b0; swNodeLow = 1'b0; lsGateLow = 1'b0;
    forceOff = 1'b0; forceLs = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int run, maxRun, total;

    // R1 reset state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 hsEn", int'(hsEn), 0);
    check("R1 lsEn", int'(lsEn), 0);
    pwmCmd = 1'b1; lsGateLow = 1'b1; swNodeLow = 1'b1;
    @(posedge clk); #1;
    check("R1 held", int'(hsEn | lsEn), 0);
    applyReset();

    // vector table, all within the first duty window
    for (int i = 0; i < 25; i++) begin
      pwmCmd = VECS[i].pwm; swNodeLow = VECS[i].sw; lsGateLow = VECS[i].lg;
      forceOff = VECS[i].fOff; forceLs = VECS[i].fLs;
      @(posedge clk); #1;
      check({reqName(VECS[i].req), " hsEn"}, int'(hsEn), int'(VECS[i].expHs));
      check({reqName(VECS[i].req), " lsEn"}, int'(lsEn), int'(VECS[i].expLs));
    end

    // R5 watchdog: node never falls
    applyReset();
    pwmCmd = 1'b1; lsGateLow = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R5 hs on", int'(hsEn), 1);
    pwmCmd = 1'b0; swNodeLow = 1'b0;
    @(posedge clk); #1;
    check("R5 hs off", int'(hsEn), 0);
    for (int k = 1; k < WD; k++) begin
      @(posedge clk); #1;
      check("R5 ls waits", int'(lsEn), 0);
    end
    @(posedge clk); #1;
    check("R5 ls on at timeout", int'(lsEn), 1);

    // R6 duty limit with request held high
    applyReset();
    pwmCmd = 1'b1; lsGateLow = 1'b1; swNodeLow = 1'b1;
    run = 0; maxRun = 0; total = 0;
    for (int k = 0; k < 3 * PERIOD; k++) begin
      @(posedge clk); #1;
      if (hsEn) begin run++; total++; end
      else run = 0;
      if (run > maxRun) maxRun = run;
    end
    check("R6 max run within limit", int'(maxRun <= DUTY), 1);
    check("R6 run near limit", int'(maxRun >= DUTY - 4), 1);
    check("R6 hs returns each period", int'(total >= 3 * (DUTY - 4)), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule